// File: doc/BRIEF.md
# Coprocessor Register Store Sequencer

This block holds a small file of 64-bit coprocessor registers and sends their contents out on a 32-bit memory data bus when the host runs a store. Each register has a high word and a low word. The host first issues a setup cycle. It then issues one or two data beats. The block answers every cycle with a registered word and a status of either "increment" (another beat is expected) or "done".

Bit 22 of the instruction decides how wide the transfer is. When the bit is clear, one word is sent. The `store_int` input chooses which half that word comes from: the low word for a 32-bit integer, the high word for a single-precision float. When the bit is set, two words are sent in a row. The `big_endian` input sets their order. A separate write port loads registers, either with a full 64-bit value or with a 32-bit integer that is sign-extended. That is how the host fills the file before it stores.

Top module: `cps_store_seq`

## Requirements
- R1: After synchronous reset, `resp_valid`, `resp_inc`, `resp_done`, `resp_err` and `rd_word` are 0, and every register entry reads as zero.
- R2: The destination register is `instr[15:12]`. When `instr[22]`=1, a data beat is part of a two-word transfer. When `instr[22]`=0, the beat is a one-word transfer, which never answers increment.
- R3: With `big_endian`=1, the first beat of a two-word transfer returns the high word and the second beat returns the low word.
- R4: With `big_endian`=0, the first beat of a two-word transfer returns the low word and the second beat returns the high word.
- R5: The first beat of a two-word transfer answers increment (`resp_inc`=1, `resp_done`=0). The second beat answers done (`resp_inc`=0, `resp_done`=1) with no error.
- R6: A setup cycle (`req_valid`=1, `req_data`=0) resets the beat count to the first beat, answers done with no error, and leaves `rd_word` unchanged.
- R7: A one-word store with `store_int`=0 (float) returns the high word of the register and answers done.
- R8: A one-word store with `store_int`=1 (integer) returns the low word of the register and answers done. It does not change the beat count.
- R9: A write with `wr_sext`=1 places `wr_data[31:0]` in the low word and fills the high word with copies of bit 31.
- R10: A write with `wr_sext`=0 stores all 64 bits, with `wr_data[63:32]` as the high word. The write takes effect at the clock edge where `wr_en`=1.
- R11: A third data beat of a two-word transfer with no setup cycle in between answers done with `resp_err`=1 and leaves `rd_word` unchanged.
- R12: Every response appears one cycle after its request, with `resp_valid`=1. In a cycle without a request, `resp_valid` is 0 in the following cycle and `rd_word` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sext | input | 1 | 1: sign-extend `wr_data[31:0]`; 0: write all 64 bits |
| wr_addr | input | 4 | Register written |
| wr_data | input | 64 | Write value (high word in bits 63:32) |
| req_valid | input | 1 | A host cycle is present |
| req_data | input | 1 | 1: data beat; 0: setup cycle |
| instr | input | 32 | Store instruction (bit 22 = long, bits 15:12 = register) |
| store_int | input | 1 | One-word store of an integer (1) or a float (0) |
| big_endian | input | 1 | Order of the two-word transfer |
| resp_valid | output | 1 | Response present |
| resp_inc | output | 1 | Another beat is expected |
| resp_done | output | 1 | Transfer complete |
| resp_err | output | 1 | Beat past the end of a two-word transfer |
| rd_word | output | 32 | Word driven on the memory data bus |

## Verification
The hardest case to reach from the ports is the third data beat of a two-word transfer, because a correct host never sends one. To reach it, the stimulus sends three long beats back to back with no setup cycle between them. It checks that the error beat repeats the previous word. It then sends a setup cycle and checks that the next long transfer starts from the first half again. Both endian modes are run on registers whose two halves differ, including a sign-extended negative value, so a swapped half or a missing extension produces a wrong word.

// File: rtl/cps_pkg.sv
package cps_pkg;

    localparam int unsigned WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t hi;
        word_t lo;
    } pair_t;

    typedef enum logic [1:0] {
        BEAT_FIRST = 2'd0,
        BEAT_NEXT  = 2'd1,
        BEAT_SPENT = 2'd2
    } beat_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_SETUP  = 2'd1,
        ACT_SINGLE = 2'd2,
        ACT_LONG   = 2'd3
    } act_e;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    typedef struct packed {
        logic  inc;
        logic  done;
        logic  err;
        logic  hold;
        logic  second;
    } status_t;

    typedef struct packed {
        logic  valid;
        logic  inc;
        logic  done;
        logic  err;
        word_t word;
    } resp_t;

    function automatic pair_t sext_load(input word_t w);
        pair_t p;
        p.lo = w;
        p.hi = {WORD_W{w[WORD_W-1]}};
        return p;
    endfunction

    function automatic half_e long_half(input logic big_endian, input logic second);
        return (big_endian ^ second) ? HALF_HI : HALF_LO;
    endfunction

    function automatic word_t pick_half(input pair_t p, input half_e h);
        return (h == HALF_HI) ? p.hi : p.lo;
    endfunction

endpackage

// File: rtl/cps_regfile.sv
module cps_regfile
    import cps_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  pair_t             wr_pair,
    input  logic [ADDR_W-1:0] rd_addr,
    output pair_t             rd_pair
);

    pair_t entry_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[g] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
                entry_q[g] <= wr_pair;
            end
        end
    end

    always_comb begin
        rd_pair = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_pair = entry_q[i];
            end
        end
    end

endmodule

// File: rtl/cps_beat_ctrl.sv
module cps_beat_ctrl
    import cps_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  act_e    act,
    output status_t status
);

    beat_e beat_q, beat_n;

    always_comb begin
        beat_n = beat_q;
        status = '0;
        unique case (act)
            ACT_NONE: begin
                status.hold = 1'b1;
            end
            ACT_SETUP: begin
                beat_n      = BEAT_FIRST;
                status.done = 1'b1;
                status.hold = 1'b1;
            end
            ACT_SINGLE: begin
                status.done = 1'b1;
            end
            ACT_LONG: begin
                unique case (beat_q)
                    BEAT_FIRST: begin
                        beat_n     = BEAT_NEXT;
                        status.inc = 1'b1;
                    end
                    BEAT_NEXT: begin
                        beat_n        = BEAT_SPENT;
                        status.done   = 1'b1;
                        status.second = 1'b1;
                    end
                    default: begin
                        beat_n      = BEAT_SPENT;
                        status.done = 1'b1;
                        status.err  = 1'b1;
                        status.hold = 1'b1;
                    end
                endcase
            end
            default: begin
                status.hold = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= BEAT_FIRST;
        end else begin
            beat_q <= beat_n;
        end
    end

endmodule

// File: rtl/cps_half_sel.sv
module cps_half_sel
    import cps_pkg::*;
(
    input  act_e  act,
    input  logic  store_int,
    input  logic  big_endian,
    input  logic  second,
    input  pair_t src,
    output word_t word
);

    half_e sel;

    always_comb begin
        if (act == ACT_LONG) begin
            sel = long_half(big_endian, second);
        end else begin
            sel = store_int ? HALF_LO : HALF_HI;
        end
        word = pick_half(src, sel);
    end

endmodule

// File: rtl/cps_store_seq.sv
module cps_store_seq
    import cps_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned ADDR_W   = $clog2(NUM_REGS),
    parameter int unsigned LONG_BIT = 22,
    parameter int unsigned DEST_LSB = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sext,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [63:0]       wr_data,
    input  logic              req_valid,
    input  logic              req_data,
    input  logic [31:0]       instr,
    input  logic              store_int,
    input  logic              big_endian,
    output logic              resp_valid,
    output logic              resp_inc,
    output logic              resp_done,
    output logic              resp_err,
    output logic [31:0]       rd_word
);

    act_e    act;
    status_t status;
    pair_t   wr_pair;
    pair_t   rd_pair;
    word_t   sel_word;
    resp_t   resp_q;

    always_comb begin
        if (!req_valid) begin
            act = ACT_NONE;
        end else if (!req_data) begin
            act = ACT_SETUP;
        end else if (instr[LONG_BIT]) begin
            act = ACT_LONG;
        end else begin
            act = ACT_SINGLE;
        end
    end

    always_comb begin
        if (wr_sext) begin
            wr_pair = sext_load(wr_data[WORD_W-1:0]);
        end else begin
            wr_pair = wr_data;
        end
    end

    cps_regfile #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_pair (wr_pair),
        .rd_addr (instr[DEST_LSB +: ADDR_W]),
        .rd_pair (rd_pair)
    );

    cps_beat_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .act    (act),
        .status (status)
    );

    cps_half_sel u_sel (
        .act        (act),
        .store_int  (store_int),
        .big_endian (big_endian),
        .second     (status.second),
        .src        (rd_pair),
        .word       (sel_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= '0;
        end else begin
            resp_q.valid <= req_valid;
            resp_q.inc   <= status.inc;
            resp_q.done  <= status.done;
            resp_q.err   <= status.err;
            if (!status.hold) begin
                resp_q.word <= sel_word;
            end
        end
    end

    assign resp_valid = resp_q.valid;
    assign resp_inc   = resp_q.inc;
    assign resp_done  = resp_q.done;
    assign resp_err   = resp_q.err;
    assign rd_word    = resp_q.word;

endmodule

// File: rtl/cps_store_seq_chk.sv
module cps_store_seq_chk #(
    parameter int unsigned LONG_BIT = 22
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_data,
    input logic [31:0] instr,
    input logic        resp_valid,
    input logic        resp_inc,
    input logic        resp_done,
    input logic        resp_err,
    input logic [31:0] rd_word
);

    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid); // R12

    AST_IDLE_NO_RESP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!resp_valid && $stable(rd_word))); // R12

    AST_ONE_STATUS: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $onehot({resp_inc, resp_done})); // R5

    AST_SETUP_DONE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_data) |=> (resp_done && !resp_err && $stable(rd_word))); // R6

    AST_SINGLE_NO_INC: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_data && !instr[LONG_BIT]) |=> (resp_done && !resp_inc)); // R2

    AST_INC_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
        (resp_inc && req_valid && req_data && instr[LONG_BIT]) |=> (resp_done && !resp_err)); // R5

    AST_ERR_HOLDS_WORD: assert property (@(posedge clk) disable iff (rst)
        resp_err |-> ($stable(rd_word) && resp_done)); // R11

endmodule

bind cps_store_seq cps_store_seq_chk #(.LONG_BIT(LONG_BIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_data   (req_data),
    .instr      (instr),
    .resp_valid (resp_valid),
    .resp_inc   (resp_inc),
    .resp_done  (resp_done),
    .resp_err   (resp_err),
    .rd_word    (rd_word)
);

// File: tb/tb_cps_store_seq.sv
`timescale 1ns/1ps
module tb_cps_store_seq;

    typedef struct {
        logic [31:0] word;
        logic        inc;
        logic        done;
        logic        err;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sext = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_data = 1'b0;
    logic [31:0] instr = '0;
    logic        store_int = 1'b0;
    logic        big_endian = 1'b0;
    logic        resp_valid, resp_inc, resp_done, resp_err;
    logic [31:0] rd_word;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    exp_t        sb[$];
    logic [63:0] model_regs [16];
    int          model_beat = 0;
    logic [31:0] model_last = '0;

    always #2.5 clk = ~clk;

    cps_store_seq dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sext(wr_sext), .wr_addr(wr_addr),
        .wr_data(wr_data), .req_valid(req_valid), .req_data(req_data), .instr(instr),
        .store_int(store_int), .big_endian(big_endian), .resp_valid(resp_valid),
        .resp_inc(resp_inc), .resp_done(resp_done), .resp_err(resp_err), .rd_word(rd_word)
    );

    task automatic check(input bit ok, input string tag, input string got, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %s expected %s", tag, got, exp);
        end
    endtask

    // monitor: pops one expected item per response
    always @(negedge clk) begin
        if (!rst && !finished && resp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R12 unexpected response", $sformatf("word=%h", rd_word), "no response");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check((rd_word === e.word) && (resp_inc === e.inc) &&
                      (resp_done === e.done) && (resp_err === e.err), e.tag,
                      $sformatf("word=%h inc=%b done=%b err=%b", rd_word, resp_inc, resp_done, resp_err),
                      $sformatf("word=%h inc=%b done=%b err=%b", e.word, e.inc, e.done, e.err));
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        wr_en     = 1'b0;
    endtask

    task automatic wr(input int addr, input logic [63:0] data, input bit sext);
        @(negedge clk);
        req_valid = 1'b0;
        wr_en     = 1'b1;
        wr_sext   = sext;
        wr_addr   = 4'(addr);
        wr_data   = data;
        if (sext) model_regs[addr] = {{32{data[31]}}, data[31:0]};
        else      model_regs[addr] = data;
    endtask

    // drives one host cycle and pushes its expected response
    task automatic issue(input bit data, input bit lng, input int addr,
                         input bit sint, input bit be, input string tag);
        exp_t e;
        logic [63:0] r;
        @(negedge clk);
        wr_en      = 1'b0;
        req_valid  = 1'b1;
        req_data   = data;
        instr      = '0;
        instr[22]  = lng;
        instr[15:12] = 4'(addr);
        store_int  = sint;
        big_endian = be;
        r = model_regs[addr];
        e.inc = 1'b0; e.done = 1'b1; e.err = 1'b0; e.word = model_last; e.tag = tag;
        if (!data) begin
            model_beat = 0;
        end else if (lng) begin
            if (model_beat == 0) begin
                e.word = be ? r[63:32] : r[31:0];
                e.inc = 1'b1; e.done = 1'b0;
                model_beat = 1;
            end else if (model_beat == 1) begin
                e.word = be ? r[31:0] : r[63:32];
                model_beat = 2;
            end else begin
                e.err = 1'b1;
            end
        end else begin
            e.word = sint ? r[31:0] : r[63:32];
        end
        model_last = e.word;
        sb.push_back(e);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model_regs[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(resp_valid === 1'b0 && resp_inc === 1'b0 && resp_done === 1'b0 &&
              resp_err === 1'b0 && rd_word === 32'h0, "R1 reset outputs",
              $sformatf("v=%b w=%h", resp_valid, rd_word), "all zero");

        // R1: register reads as zero after reset
        issue(1, 0, 5, 1, 0, "R1 entry low word zero");
        issue(1, 0, 9, 0, 0, "R1 entry high word zero");

        // R10 full writes, R9 sign-extended writes
        wr(1, 64'h1111_2222_3333_4444, 0);
        wr(2, 64'h5555_5555_8000_0001, 1);
        wr(3, 64'hABCD_0000_7FFF_0000, 1);
        idle();

        // R3 big-endian long, R5 status, R11 extra beat
        issue(0, 1, 1, 0, 1, "R6 setup done");
        issue(1, 1, 1, 0, 1, "R3 R5 BE first beat high");
        issue(1, 1, 1, 0, 1, "R3 R5 BE second beat low");
        issue(1, 1, 1, 0, 1, "R11 third beat error hold");
        issue(0, 1, 1, 0, 1, "R6 setup holds word");

        // R4 little-endian long on sign-extended negative
        issue(1, 1, 2, 0, 0, "R4 R9 LE first beat low");
        issue(1, 1, 2, 0, 0, "R4 R9 LE second beat high");
        issue(0, 1, 2, 0, 0, "R6 setup");
        issue(1, 1, 3, 0, 0, "R4 R9 positive sext low");
        issue(1, 1, 3, 0, 0, "R4 R9 positive sext high zero");

        // R7 R8 singles, R2 single never increments
        issue(0, 0, 1, 0, 0, "R6 setup");
        issue(1, 0, 1, 0, 0, "R7 float single high");
        issue(1, 0, 1, 1, 0, "R8 int single low");
        issue(1, 0, 2, 1, 1, "R2 R8 single ignores endian");
        // R8: single does not advance count; long still starts at first beat
        issue(1, 1, 1, 0, 1, "R8 R2 long after single first");
        issue(1, 0, 3, 0, 0, "R7 single between beats");
        issue(1, 1, 1, 0, 1, "R5 long second after single");
        idle();
        idle();

        // R12 idle cycles: no response, word held
        begin
            logic [31:0] held;
            held = rd_word;
            idle();
            check(resp_valid === 1'b0 && rd_word === held && sb.size() == 0,
                  "R12 idle no response",
                  $sformatf("v=%b w=%h q=%0d", resp_valid, rd_word, sb.size()),
                  $sformatf("v=0 w=%h q=0", held));
        end

        // sweep all entries in both modes
        for (int i = 0; i < 16; i++) begin
            wr(i, {32'(i * 32'h0101_0101) ^ 32'hF000_000F, 32'(i * 32'h1357_9BDF)}, i[0]);
        end
        for (int i = 0; i < 16; i++) begin
            issue(0, 1, i, 0, i[1], "R6 sweep setup");
            issue(1, 1, i, 0, i[1], "R3 R4 sweep first");
            issue(1, 1, i, 0, i[1], "R3 R4 sweep second");
        end
        // R10 overwrite of an entry
        wr(4, 64'hDEAD_BEEF_CAFE_F00D, 0);
        issue(1, 0, 4, 0, 0, "R10 overwrite high");
        issue(1, 0, 4, 1, 0, "R10 overwrite low");
        idle();
        idle();
        idle();
        check(sb.size() == 0, "R12 all responses seen",
              $sformatf("%0d left", sb.size()), "0 left");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule